// File: doc/BRIEF.md
# Dual Three-Port Parallel I/O Controller

This block gives a host a byte-wide register window onto 48 general-purpose lines. The lines are split into two identical groups, and each group holds three 8-bit ports named A, B and C. Every port has an output latch that drives its lines, and a read of the port returns the live level on its lines. Each group has one control byte that chooses the direction of port A and port B as whole bytes, and of port C as two separate nibbles.

The host uses a 4-bit address with separate read and write strobes. Group 0 occupies offsets 0 to 3 and group 1 occupies offsets 4 to 7. Offsets 8 to 15 are unused. The lines are numbered so that line = 8 × port index + bit, where port indices 0 to 2 are group 0's A, B and C and indices 3 to 5 are group 1's A, B and C. Each line is presented to the pad ring as an input level, an output level and an output enable.

Top module: `pio_dual48`

## Requirements
- R1: Within group g (g = 0 or 1), offset 4g+0 selects port A, 4g+1 selects port B, 4g+2 selects port C and 4g+3 selects the control byte. Line number = 8 × (3g + port) + bit, where A=0, B=1 and C=2.
- R2: After reset, every line has its output enable at 1 and its output level at 0, and a read of either control offset returns 0x80.
- R3: A write to a data offset places wdata into that port's output latch, and pin_out shows the new value in the cycle after the write strobe. This applies whether the port is currently an input or an output.
- R4: A control write with bit 7 = 1 sets the direction of the group's ports. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 3 = 1 makes port C bits 7..4 inputs and bit 0 = 1 makes port C bits 3..0 inputs. A 0 in any of these bits makes the matching lines outputs. The new directions take effect in the cycle after the strobe.
- R5: A control write with bit 7 = 0 changes no direction.
- R6: pin_oe of each line is 1 exactly when that line is set as an output. A line set as an input is never driven.
- R7: A read of a data offset returns that port's pin_in levels on rdata in the cycle after the read strobe.
- R8: A read of a control offset returns 0x80 OR'd with the stored bits 4, 3, 1 and 0. All other bits read 0.
- R9: Writes to offsets 8 to 15 change no latch and no direction. Reads from offsets 8 to 15 return 0x00.
- R10: rdata keeps its last value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Sampled line levels |
| pin_out | output | 48 | Output latch levels |
| pin_oe | output | 48 | Per-line output enable |

## Verification
Every result is due exactly one clock after its strobe. Latch writes appear on pin_out, control writes appear on pin_oe, and reads appear on rdata at the first rising edge after the strobe is sampled. The bench raises each strobe just after a falling edge, lowers it at the next falling edge and reads the outputs there. That point is half a cycle after the edge that updates them, so every check falls in the cycle the requirement names. The bound properties state the same one-cycle relation with |=> and compare against $past of the strobed data.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int CTL_W      = 8;
  localparam int CTL_VALID  = 7;
  localparam int CTL_A_IN   = 4;
  localparam int CTL_CH_IN  = 3;
  localparam int CTL_B_IN   = 1;
  localparam int CTL_CL_IN  = 0;
  localparam int PORTS_PER_GROUP = 3;

  typedef struct packed {
    logic a_in;
    logic ch_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  function automatic dir_t ctl_decode(input logic [CTL_W-1:0] b);
    dir_t d;
    d.a_in  = b[CTL_A_IN];
    d.ch_in = b[CTL_CH_IN];
    d.b_in  = b[CTL_B_IN];
    d.cl_in = b[CTL_CL_IN];
    return d;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_encode(input dir_t d);
    logic [CTL_W-1:0] b;
    b = '0;
    b[CTL_VALID] = 1'b1;
    b[CTL_A_IN]  = d.a_in;
    b[CTL_CH_IN] = d.ch_in;
    b[CTL_B_IN]  = d.b_in;
    b[CTL_CL_IN] = d.cl_in;
    return b;
  endfunction

endpackage

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [PORTS_PER_GROUP-1:0]          wr_lat,
  input  logic                                wr_ctl,
  input  logic [PORT_W-1:0]                   wdata,
  output logic [PORTS_PER_GROUP*PORT_W-1:0]   lat_q,
  output logic [PORTS_PER_GROUP*PORT_W-1:0]   oe,
  output logic [CTL_W-1:0]                    ctl_rd
);
  localparam int HALF = PORT_W / 2;

  dir_t dir_q;

  // Output latches: written regardless of current direction.
  for (genvar p = 0; p < PORTS_PER_GROUP; p++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)            lat_q[p*PORT_W +: PORT_W] <= '0;
      else if (wr_lat[p]) lat_q[p*PORT_W +: PORT_W] <= wdata;
    end
  end

  // Direction bits: only a control byte with the valid flag is taken.
  always_ff @(posedge clk) begin
    if (rst)
      dir_q <= '0;
    else if (wr_ctl && wdata[CTL_VALID])
      dir_q <= ctl_decode(wdata[CTL_W-1:0]);
  end

  assign oe = { {HALF{~dir_q.ch_in}}, {HALF{~dir_q.cl_in}},
                {PORT_W{~dir_q.b_in}}, {PORT_W{~dir_q.a_in}} };

  assign ctl_rd = ctl_encode(dir_q);

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import pio_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int PORT_W     = 8,
  parameter int ADDR_W     = 4
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       rd_en,
  input  logic [ADDR_W-1:0]                          addr,
  input  logic [NUM_GROUPS*PORTS_PER_GROUP*PORT_W-1:0] pin_in,
  input  logic [NUM_GROUPS*CTL_W-1:0]                ctl_all,
  output logic [PORT_W-1:0]                          rdata
);
  localparam int GRP_W = ADDR_W - 2;

  logic [GRP_W-1:0]  grp;
  logic [1:0]        sel;
  logic [PORT_W-1:0] rd_next;

  assign grp = addr[ADDR_W-1:2];
  assign sel = addr[1:0];

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp == GRP_W'(g)) begin
        if (sel == 2'd3)
          rd_next = PORT_W'(ctl_all[g*CTL_W +: CTL_W]);
        else
          rd_next = pin_in[(g*PORTS_PER_GROUP + int'(sel))*PORT_W +: PORT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

endmodule

// File: rtl/pio_dual48.sv
module pio_dual48
  import pio_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int PORT_W     = 8,
  parameter int ADDR_W     = 4,
  localparam int LINES     = NUM_GROUPS * PORTS_PER_GROUP * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe
);
  localparam int GRP_W   = ADDR_W - 2;
  localparam int GLINES  = PORTS_PER_GROUP * PORT_W;

  logic [GRP_W-1:0]           grp;
  logic [1:0]                 sel;
  logic [NUM_GROUPS*CTL_W-1:0] ctl_all;

  assign grp = addr[ADDR_W-1:2];
  assign sel = addr[1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic                       hit;
    logic [PORTS_PER_GROUP-1:0] wr_lat;

    assign hit = wr_en && (grp == GRP_W'(g));
    for (genvar p = 0; p < PORTS_PER_GROUP; p++) begin : g_dec
      assign wr_lat[p] = hit && (sel == 2'(p));
    end

    pio_group #(.PORT_W(PORT_W)) u_group (
      .clk    (clk),
      .rst    (rst),
      .wr_lat (wr_lat),
      .wr_ctl (hit && (sel == 2'd3)),
      .wdata  (wdata),
      .lat_q  (pin_out[g*GLINES +: GLINES]),
      .oe     (pin_oe[g*GLINES +: GLINES]),
      .ctl_rd (ctl_all[g*CTL_W +: CTL_W])
    );
  end

  pio_rdmux #(
    .NUM_GROUPS (NUM_GROUPS),
    .PORT_W     (PORT_W),
    .ADDR_W     (ADDR_W)
  ) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .pin_in  (pin_in),
    .ctl_all (ctl_all),
    .rdata   (rdata)
  );

endmodule

// File: rtl/pio_dual48_chk.sv
module pio_dual48_chk #(
  parameter int NUM_GROUPS = 2,
  parameter int PORT_W     = 8,
  parameter int ADDR_W     = 4,
  localparam int LINES     = NUM_GROUPS * 3 * PORT_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [PORT_W-1:0] wdata,
  input logic [PORT_W-1:0] rdata,
  input logic [LINES-1:0]  pin_in,
  input logic [LINES-1:0]  pin_out,
  input logic [LINES-1:0]  pin_oe
);

  // R2: reset leaves every line driven low
  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (pin_oe == '1) && (pin_out == '0));

  // R3: port A latch of group 0 follows the write one cycle later
  assert_latch_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(0)) |=> pin_out[PORT_W-1:0] == $past(wdata));

  // R4 / R6: port A enable follows bit 4 of a valid control write
  assert_dir_a_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(3) && wdata[7])
      |=> pin_oe[PORT_W-1:0] == {PORT_W{~$past(wdata[4])}});

  // R5: control byte without the valid flag leaves directions alone
  assert_ctl_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1:0] == 2'd3 && !wdata[7]) |=> $stable(pin_oe));

  // R9: no write strobe, or an unused offset, leaves the pins alone
  assert_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || addr >= ADDR_W'(8)) |=> $stable(pin_out) && $stable(pin_oe));

  // R7: read of port B, group 0 returns pin levels one cycle later
  assert_read_pins_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(1)) |=> rdata == $past(pin_in[2*PORT_W-1:PORT_W]));

  // R10: rdata holds without a read strobe
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind pio_dual48 pio_dual48_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .PORT_W     (PORT_W),
  .ADDR_W     (ADDR_W)
) u_chk (.*);

// File: tb/pio_dual48_bench.sv
`timescale 1ns/1ps
module pio_dual48_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic [47:0] pin_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pio_dual48 u_pio_dual48 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {ctl group0, ctl group1, expected pin_oe} applied in order
  localparam logic [63:0] VEC [7] = '{
    {8'h80, 8'h80, 48'hFFFFFF_FFFFFF},
    {8'h9B, 8'h80, 48'hFFFFFF_000000},
    {8'h90, 8'h82, 48'hFF00FF_FFFF00},
    {8'h88, 8'h81, 48'hF0FFFF_0FFFFF},
    {8'hFF, 8'h80, 48'hFFFFFF_000000},
    {8'h80, 8'h9B, 48'h000000_FFFFFF},
    {8'h1B, 8'h1B, 48'h000000_FFFFFF}
  };

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [7:0] r;
    logic [47:0] oe_snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    check("R2 oe", pin_oe, '1);
    check("R2 out", pin_out, '0);
    bus_rd(4'd3, r); check("R2 ctl0", 48'(r), 48'h80);
    bus_rd(4'd7, r); check("R2 ctl1", 48'(r), 48'h80);

    // R4 R5 R6: direction table
    for (int i = 0; i < 7; i++) begin
      bus_wr(4'd3, VEC[i][63:56]);
      bus_wr(4'd7, VEC[i][55:48]);
      check((i == 6) ? "R5 ctl ignored" : "R4 R6 dir", pin_oe, VEC[i][47:0]);
    end

    // R8: control readback keeps bits 4,3,1,0 only (group1 holds 0x9B)
    bus_rd(4'd7, r); check("R8 ctl1", 48'(r), 48'h9B);
    bus_wr(4'd3, 8'hFF);
    bus_rd(4'd3, r); check("R8 ctl0 from FF", 48'(r), 48'h9B);
    bus_wr(4'd3, 8'h80);

    // R1 R3: latch writes, timing one cycle after strobe
    @(negedge clk); addr = 4'd0; wdata = 8'hA5; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R3 A0 next cycle", 48'(pin_out[7:0]), 48'hA5);
    bus_wr(4'd2, 8'h3C); check("R1 C0 lines 23..16", 48'(pin_out[23:16]), 48'h3C);
    // group1 is all inputs: latch still updates, not driven
    bus_wr(4'd5, 8'h5A); check("R3 B1 while input", 48'(pin_out[39:32]), 48'h5A);
    check("R6 B1 not driven", 48'(pin_oe[39:32]), 48'h00);
    bus_wr(4'd6, 8'hC3); check("R1 C1 lines 47..40", 48'(pin_out[47:40]), 48'hC3);
    check("R1 A1 untouched", 48'(pin_out[31:24]), 48'h00);

    // R7: pin reads
    pin_in = 48'h112233_445566;
    bus_rd(4'd1, r); check("R7 B0", 48'(r), 48'h55);
    bus_rd(4'd4, r); check("R7 A1", 48'(r), 48'h33);
    bus_rd(4'd6, r); check("R7 C1", 48'(r), 48'h11);

    // R10: hold without strobe
    pin_in = 48'hFFFFFF_FFFFFF;
    repeat (3) @(negedge clk);
    check("R10 hold", 48'(rdata), 48'h11);

    // R9: unused offsets
    oe_snap = pin_oe;
    bus_wr(4'd8, 8'hEE);
    bus_wr(4'd11, 8'h80);
    check("R9 out unchanged", pin_out, 48'hC35A00_3C00A5);
    check("R9 oe unchanged", pin_oe, oe_snap);
    bus_rd(4'd12, r); check("R9 read zero", 48'(r), 48'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule